// File: doc/BRIEF.md
# Masked Control Register with Write Aliases

This block holds a single 64-bit control/status register behind a small register-access bus. Only the upper sixteen bits of the register exist in storage; the lower 48 bits always read as zero. Software changes the register through a few neighbouring offsets, which are aliases of the same storage. One offset replaces the value. A second offset either ANDs the old value with the write data or clears the register outright, depending on the variant. A third offset ORs the write data into the old value. The most significant register bit is driven straight out as a level-sensitive interrupt request.

A parameter picks one of two address maps. Variant 0 places the register at offset 0x4020 with an AND alias at 0x4021 and an OR alias at 0x4022. Variant 1 places it at 0x6080 with a clear alias at 0x6081 and an OR alias at 0x6082. The offset is the byte address shifted right by three. Only aligned, full eight-byte accesses are legal. Data on the bus is big-endian: byte lane 0 carries the register's most significant byte.

Requests use a valid/ready handshake and each one produces exactly one response on a valid/ready response channel. The response buffer holds one entry. A new request is accepted only when that entry is empty or is being drained in the same cycle, so back-pressure on the response side stalls the request side.

Top module: `misc_alias_reg`

## Requirements
- R1: After reset the stored value is zero, `irq_o` is low and `rsp_valid` is low.
- R2: Only register bits 63..48 are stored. Bits 47..0 of every write are discarded, and they read back as zero.
- R3: A write to the main offset (0x4020 in variant 0, 0x6080 in variant 1) stores the write data. A read of the main offset returns the stored value with `rsp_err` low.
- R4: In variant 0, a write to offset 0x4021 stores the old value ANDed with the write data.
- R5: A write to the OR alias (0x4022 in variant 0, 0x6082 in variant 1) stores the old value ORed with the write data.
- R6: In variant 1, a write to offset 0x6081 clears the register to zero whatever the write data is.
- R7: `irq_o` equals register bit 63. It changes on the clock edge that accepts the write, which is the same edge that updates the stored value.
- R8: Any other offset is unimplemented, and this includes reads of the alias offsets. Such an access changes nothing, gives `rsp_err` = 1, and returns read data 0.
- R9: An access whose `req_be` is not all ones, or whose byte address has bits 2..0 not equal to zero, changes nothing, gives `rsp_err` = 1, and returns read data 0.
- R10: Bus data is big-endian. Bus bits [8k+7:8k] carry register bits [63-8k:56-8k] on both write data and read data.
- R11: A request is accepted when `req_valid` and `req_ready` are both high, and `req_ready` = !`rsp_valid` || `rsp_ready`. The response appears in the cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the response data and the error flag hold steady.
- R12: Parameter `VARIANT` selects the address map. In variant 1 the variant 0 offsets are unimplemented, and in variant 0 the variant 1 offsets are unimplemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | DATA_W/8 | Byte enables; must be all ones |
| req_wdata | input | DATA_W | Write data, big-endian lanes |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | DATA_W | Read data, big-endian lanes |
| rsp_err | output | 1 | Access was unimplemented or malformed |
| irq_o | output | 1 | Level interrupt, equals register bit 63 |

## Verification
The assertions assume that every request input is at a known value whenever `req_valid` is high, and that reset is held for at least one clock edge. They also assume the consumer does not rely on `req_ready` before reset has been released. The stimulus drives every request field on the falling clock edge and holds it until the request is accepted. The bench drives the same request bus into one instance of each variant, so every address is legal for at most one of them and the error path is exercised all through the sequence. Response back-pressure is applied only by lowering `rsp_ready` between requests, so the response hold property is tested with real stalls rather than only in the idle case.

// File: rtl/misc_alias_pkg.sv
package misc_alias_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_READ  = 3'd1,
    OP_SET   = 3'd2,
    OP_AND   = 3'd3,
    OP_OR    = 3'd4,
    OP_CLEAR = 3'd5
  } op_e;

  // Base doubleword offset of the register for each address map.
  function automatic int map_base(input int variant);
    return (variant == 0) ? 32'h4020 : 32'h6080;
  endfunction

endpackage

// File: rtl/misc_alias_swap.sv
module misc_alias_swap #(
  parameter int DATA_W     = 64,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / 8;

  generate
    if (BIG_ENDIAN) begin : g_swap
      for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[8*i +: 8] = din[8*(LANES-1-i) +: 8];
      end
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/misc_alias_decode.sv
module misc_alias_decode
  import misc_alias_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 64,
  parameter int VARIANT = 0
) (
  input  logic                  acc_i,
  input  logic                  write_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W/8-1:0]   be_i,
  output op_e                   op_o,
  output logic                  err_o
);
  localparam int OFF_W = ADDR_W - 3;
  localparam logic [OFF_W-1:0] OFF_MAIN = OFF_W'(map_base(VARIANT));
  localparam logic [OFF_W-1:0] OFF_AL1  = OFF_W'(map_base(VARIANT) + 1);
  localparam logic [OFF_W-1:0] OFF_AL2  = OFF_W'(map_base(VARIANT) + 2);

  logic [OFF_W-1:0] off;
  logic             well_formed;
  op_e              alias1_op;
  op_e              raw_op;

  assign off         = addr_i[ADDR_W-1:3];
  assign well_formed = (addr_i[2:0] == 3'b000) && (&be_i);

  generate
    if (VARIANT == 0) begin : g_map_and
      assign alias1_op = OP_AND;
    end else begin : g_map_clear
      assign alias1_op = OP_CLEAR;
    end
  endgenerate

  always_comb begin
    raw_op = OP_NONE;
    if (write_i) begin
      if (off == OFF_MAIN)      raw_op = OP_SET;
      else if (off == OFF_AL1)  raw_op = alias1_op;
      else if (off == OFF_AL2)  raw_op = OP_OR;
    end else if (off == OFF_MAIN) begin
      raw_op = OP_READ;
    end
  end

  always_comb begin
    err_o = acc_i && (!well_formed || raw_op == OP_NONE);
    op_o  = (acc_i && !err_o) ? raw_op : OP_NONE;
  end
endmodule

// File: rtl/misc_alias_store.sv
module misc_alias_store
  import misc_alias_pkg::*;
#(
  parameter int KEEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op_i,
  input  logic [KEEP_W-1:0] wbits_i,
  output logic [KEEP_W-1:0] keep_q,
  output logic              irq_o
);
  logic [KEEP_W-1:0] keep_d;

  always_comb begin
    case (op_i)
      OP_SET:   keep_d = wbits_i;
      OP_AND:   keep_d = keep_q & wbits_i;
      OP_OR:    keep_d = keep_q | wbits_i;
      OP_CLEAR: keep_d = '0;
      default:  keep_d = keep_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) keep_q <= '0;
    else        keep_q <= keep_d;
  end

  assign irq_o = keep_q[KEEP_W-1];

  // R4: the AND alias combines the old value with the write data
  p_and_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_AND |=> keep_q == ($past(keep_q) & $past(wbits_i)));

  // R5: the OR alias combines the old value with the write data
  p_or_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_OR |=> keep_q == ($past(keep_q) | $past(wbits_i)));

  // R6: the clear alias empties the register and drops the interrupt
  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_CLEAR |=> (keep_q == '0) && !irq_o);

  // R7: a direct write with the top bit set raises the interrupt on the next edge
  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SET && wbits_i[KEEP_W-1]) |=> irq_o);
endmodule

// File: rtl/misc_alias_resp.sv
module misc_alias_resp #(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              err_i,
  input  logic              rsp_ready,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rdata_q,
  output logic              err_q
);
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rdata_q   <= '0;
      err_q     <= 1'b0;
    end else begin
      if (acc_i) begin
        rsp_valid <= 1'b1;
        rdata_q   <= rdata_i;
        err_q     <= err_i;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R11: a stalled response keeps its payload
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rdata_q) && $stable(err_q));

  // R2: the non-stored bits never leave the block as anything but zero
  p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rdata_q[DATA_W-KEEP_W-1:0] == '0);
endmodule

// File: rtl/misc_alias_reg.sv
module misc_alias_reg
  import misc_alias_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 64,
  parameter int KEEP_W     = 16,
  parameter int VARIANT    = 0,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  output logic                irq_o
);
  localparam int LOW_W = DATA_W - KEEP_W;

  logic              accept;
  op_e               op;
  logic              err;
  logic [DATA_W-1:0] wdata_reg;
  logic [KEEP_W-1:0] keep_q;
  logic [DATA_W-1:0] rd_reg;
  logic [DATA_W-1:0] rd_q;

  assign accept = req_valid && req_ready;

  misc_alias_swap #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_swap_in (
    .din  (req_wdata),
    .dout (wdata_reg)
  );

  misc_alias_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VARIANT(VARIANT)) u_decode (
    .acc_i   (accept),
    .write_i (req_write),
    .addr_i  (req_addr),
    .be_i    (req_be),
    .op_o    (op),
    .err_o   (err)
  );

  misc_alias_store #(.KEEP_W(KEEP_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op),
    .wbits_i (wdata_reg[DATA_W-1:LOW_W]),
    .keep_q  (keep_q),
    .irq_o   (irq_o)
  );

  assign rd_reg = (op == OP_READ) ? {keep_q, {LOW_W{1'b0}}} : '0;

  misc_alias_resp #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_i     (accept),
    .rdata_i   (rd_reg),
    .err_i     (err),
    .rsp_ready (rsp_ready),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rdata_q   (rd_q),
    .err_q     (rsp_err)
  );

  misc_alias_swap #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_swap_out (
    .din  (rd_q),
    .dout (rsp_rdata)
  );

  // R8/R9: a rejected access leaves the register untouched
  p_reject_noeffect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && err) |=> $stable(keep_q));

  // R9: partial byte enables produce an error response
  p_partial_be_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(&req_be)) |=> rsp_valid && rsp_err);
endmodule

// File: tb/misc_alias_reg_tb.sv
module misc_alias_reg_tb;
  localparam int ADDR_W = 20;
  localparam int CLK_NS = 20;

  typedef struct packed {
    logic [63:0] rd_a; logic err_a; logic irq_a;
    logic [63:0] rd_b; logic err_b; logic irq_b;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0]  req_be = 8'hFF;
  logic [63:0] req_wdata = '0;
  logic req_ready_a, rsp_valid_a, rsp_err_a, irq_a;
  logic req_ready_b, rsp_valid_b, rsp_err_b, irq_b;
  logic [63:0] rdata_a, rdata_b;

  int vectors = 0, misses = 0;
  exp_t exp_q[$];
  string tag_q[$];
  logic [15:0] m_a = '0, m_b = '0;

  always #(CLK_NS/2) clk = ~clk;

  misc_alias_reg #(.ADDR_W(ADDR_W), .VARIANT(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_a),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_a), .rsp_ready(rsp_ready), .rsp_rdata(rdata_a),
    .rsp_err(rsp_err_a), .irq_o(irq_a));

  misc_alias_reg #(.ADDR_W(ADDR_W), .VARIANT(1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_b),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_b), .rsp_ready(rsp_ready), .rsp_rdata(rdata_b),
    .rsp_err(rsp_err_b), .irq_o(irq_b));

  function automatic logic [63:0] bswap(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 8; i++) y[63-8*i -: 8] = x[8*i +: 8];
    return y;
  endfunction

  // Reference model from the requirements (R2..R9, R12)
  function automatic void predict(input int v, input logic wr, input logic [ADDR_W-1:0] a,
                                  input logic [7:0] be, input logic [63:0] wd,
                                  input logic [15:0] m_in, output logic [15:0] m_out,
                                  output logic [63:0] rd, output logic err);
    int base, off;
    logic ok;
    base = (v == 0) ? 32'h4020 : 32'h6080;
    off  = int'(a >> 3);
    ok   = (be == 8'hFF) && (a[2:0] == 3'b000);
    m_out = m_in; rd = '0; err = 1'b1;
    if (ok) begin
      if (!wr && off == base) begin rd = {m_in, 48'h0}; err = 1'b0; end
      else if (wr && off == base) begin m_out = wd[63:48]; err = 1'b0; end
      else if (wr && off == base + 1) begin
        m_out = (v == 0) ? (m_in & wd[63:48]) : 16'h0; err = 1'b0;
      end else if (wr && off == base + 2) begin m_out = m_in | wd[63:48]; err = 1'b0; end
    end
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: wdata given in register order, converted to big-endian lanes (R10)
  task automatic send(input string req, input logic wr, input logic [ADDR_W-1:0] a,
                      input logic [7:0] be, input logic [63:0] wd);
    exp_t e;
    logic [15:0] na, nb;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = bswap(wd);
    while (!req_ready_a) @(negedge clk);
    predict(0, wr, a, be, wd, m_a, na, e.rd_a, e.err_a);
    predict(1, wr, a, be, wd, m_b, nb, e.rd_b, e.err_b);
    m_a = na; m_b = nb;
    e.irq_a = na[15]; e.irq_b = nb[15];
    exp_q.push_back(e); tag_q.push_back(req);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pops one expected item per delivered response
  always @(negedge clk) begin
    #3;
    if (rst_n && rsp_valid_a && rsp_ready) begin
      exp_t e;
      string t;
      if (exp_q.size() == 0) begin
        check("R11", "unexpected response", 64'd1, 64'd0);
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check("R11", "variant1 response alignment", {63'd0, rsp_valid_b}, 64'd1);
        check(t, "variant0 rdata", rdata_a, bswap(e.rd_a));
        check(t, "variant0 err", {63'd0, rsp_err_a}, {63'd0, e.err_a});
        check(t, "variant0 irq (R7)", {63'd0, irq_a}, {63'd0, e.irq_a});
        check(t, "variant1 rdata", rdata_b, bswap(e.rd_b));
        check(t, "variant1 err", {63'd0, rsp_err_b}, {63'd0, e.err_b});
        check(t, "variant1 irq (R7)", {63'd0, irq_b}, {63'd0, e.irq_b});
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    #3;
    check("R1", "irq after reset", {62'd0, irq_a, irq_b}, 64'd0);
    check("R1", "rsp_valid after reset", {62'd0, rsp_valid_a, rsp_valid_b}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    send("R1",  1'b0, 20'h20100, 8'hFF, 64'h0);                    // read, zero after reset
    send("R3",  1'b1, 20'h20100, 8'hFF, 64'hDEAD_BEEF_1234_5678);
    send("R2",  1'b0, 20'h20100, 8'hFF, 64'h0);                    // low bits read as zero
    send("R10", 1'b0, 20'h20100, 8'hFF, 64'h0);                    // lane 0 carries 0xDE
    send("R4",  1'b1, 20'h20108, 8'hFF, 64'h0F0F_FFFF_FFFF_FFFF);
    send("R4",  1'b0, 20'h20100, 8'hFF, 64'h0);
    send("R5",  1'b1, 20'h20110, 8'hFF, 64'h8000_0000_0000_0001);
    send("R5",  1'b0, 20'h20100, 8'hFF, 64'h0);
    send("R12", 1'b1, 20'h30400, 8'hFF, 64'h1234_FFFF_0000_0000);
    send("R5",  1'b1, 20'h30410, 8'hFF, 64'hC000_0000_0000_0000);
    send("R12", 1'b0, 20'h30400, 8'hFF, 64'h0);
    send("R6",  1'b1, 20'h30408, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
    send("R6",  1'b0, 20'h30400, 8'hFF, 64'h0);
    send("R3",  1'b1, 20'h30400, 8'hFF, 64'hA5A5_0000_0000_0000);
    send("R9",  1'b1, 20'h30400, 8'h7F, 64'h0101_0000_0000_0000); // partial enables
    send("R9",  1'b1, 20'h30404, 8'hFF, 64'h0202_0000_0000_0000); // misaligned
    send("R9",  1'b0, 20'h30400, 8'hFE, 64'h0);
    send("R9",  1'b0, 20'h30400, 8'hFF, 64'h0);
    send("R8",  1'b1, 20'h20118, 8'hFF, 64'hFFFF_0000_0000_0000); // unimplemented
    send("R8",  1'b0, 20'h20108, 8'hFF, 64'h0);                    // read of alias
    send("R8",  1'b0, 20'h20100, 8'hFF, 64'h0);
    send("R7",  1'b1, 20'h20100, 8'hFF, 64'h7FFF_0000_0000_0000);
    send("R7",  1'b1, 20'h20110, 8'hFF, 64'h8000_0000_0000_0000);

    // R11: response back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    send("R11", 1'b0, 20'h30400, 8'hFF, 64'h0);
    #3;
    held = rdata_b;
    check("R11", "req_ready while stalled", {63'd0, req_ready_a}, 64'd0);
    repeat (2) @(negedge clk);
    #3;
    check("R11", "rsp_valid held", {63'd0, rsp_valid_a}, 64'd1);
    check("R11", "rdata held", rdata_b, held);
    @(negedge clk); rsp_ready = 1'b1;

    repeat (4) @(negedge clk);
    check("R11", "all responses delivered", 64'(exp_q.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule